// File: doc/BRIEF.md
# Rotating-Turn Shared Helper Port Arbiter

This block shares one helper engine among several processor cores. Each cycle one core owns the turn. The turn passes to the next core on every clock, whether or not its owner used it. Each core presents a request bit and a payload, for example a load PC or a miss address. The block captures these in a register stage. It then decides combinationally which cores reach the helper's ports, returns a grant to each winning core and steers the winning payloads onto the helper ports.

The turn owner always wins port 0 when it requests. When it does not, the slot is donated to another requester rather than left idle. A helper with more than one port takes further winners in the same rotated order. A core is treated as not requesting in three cases: it does not assert its request, it asserts its flush line, or its enable bit for this helper is clear.

Top module: `helper_turn_arb`

## Requirements
- R1: While reset is asserted, `turn_o` is 0, `grant_o` is all zeros and every `port_valid_o` bit is 0.
- R2: After reset, `turn_o` increases by one on every clock edge and wraps from NUM_CORES-1 to 0, regardless of request activity.
- R3: A core is eligible in a cycle when it held `req_i`=1, `flush_i`=0 and `enable_i`=1 at the previous clock edge. If the turn owner is eligible, it is placed on port 0.
- R4: If the turn owner is not eligible, port 0 goes to the first eligible core found by scanning core indices upward from owner+1 and wrapping modulo NUM_CORES.
- R5: Port k (k>0) goes to the (k+1)-th eligible core of that same scan, which starts at the owner. A port with no remaining candidate has its valid bit at 0. Valid ports are always the lowest-numbered ones.
- R6: A core whose flush line was high at the capturing edge is never granted in the following cycle.
- R7: A core whose enable bit was 0 at the capturing edge is never granted, and it takes no port from another core.
- R8: `grant_o` has a 1 exactly for the cores shown on valid ports. No core appears on two ports.
- R9: Port k carries the index of its core on `port_core_o[k*IDX_W +: IDX_W]`. It carries that core's captured payload on `port_data_o[k*PAYLOAD_W +: PAYLOAD_W]`.
- R10: Outputs reflect the inputs sampled at the most recent clock edge, one cycle of latency, and hold until the next edge.
- R11: A port whose valid bit is 0 drives all-zero data and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CORES | Per-core request |
| flush_i | input | NUM_CORES | Per-core flush; suppresses that core's request |
| enable_i | input | NUM_CORES | Per-core enable for this helper |
| payload_i | input | NUM_CORES*PAYLOAD_W | Per-core payload, core c at bits c*PAYLOAD_W |
| turn_o | output | IDX_W | Index of the core owning the current turn |
| grant_o | output | NUM_CORES | Per-core grant for the current cycle |
| port_valid_o | output | NUM_PORTS | Helper port k carries a request |
| port_core_o | output | NUM_PORTS*IDX_W | Core index on each helper port |
| port_data_o | output | NUM_PORTS*PAYLOAD_W | Payload on each helper port |

## Verification
A wrong turn pointer shows up on `turn_o` in the first cycle after reset. It also moves every grant decision that cycle, because the owner's priority shifts. A mistake in the rotated scan, such as a missing wrap or a wrong start, appears as a wrong `port_core_o` in the first cycle whose eligible set straddles the wrap point. A masking error, where a flushed or disabled core still counts, shows as a grant to that core one cycle after the masked request. Random mixes of request, flush and enable patterns expose these across every turn position within a few hundred cycles. Directed cases pin the wrap and the all-idle cases.

// File: rtl/helper_arb_pkg.sv
package helper_arb_pkg;

   // Add an offset to a core index and wrap it modulo the core count.
   function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                            int unsigned n);
      int unsigned s;
      s = base + off;
      while (s >= n) s = s - n;
      return s;
   endfunction

endpackage

// File: rtl/turn_ring.sv
module turn_ring #(
   parameter int NUM_CORES = 4,
   localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] turn_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CORES - 1);

   logic [IDX_W-1:0] turn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         turn_q <= '0;
      else if (turn_q == LAST)
         turn_q <= '0;
      else
         turn_q <= turn_q + IDX_W'(1);
   end

   assign turn_o = turn_q;
endmodule

// File: rtl/req_stage.sv
module req_stage #(
   parameter int NUM_CORES = 4,
   parameter int PAYLOAD_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CORES-1:0]           req_i,
   input  logic [NUM_CORES-1:0]           flush_i,
   input  logic [NUM_CORES-1:0]           enable_i,
   input  logic [NUM_CORES*PAYLOAD_W-1:0] payload_i,
   output logic [NUM_CORES-1:0]           elig_o,
   output logic [NUM_CORES*PAYLOAD_W-1:0] payload_o
);
   logic [NUM_CORES-1:0]           elig_q;
   logic [NUM_CORES*PAYLOAD_W-1:0] pay_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elig_q <= '0;
         pay_q  <= '0;
      end else begin
         elig_q <= req_i & ~flush_i & enable_i;
         pay_q  <= payload_i;
      end
   end

   assign elig_o    = elig_q;
   assign payload_o = pay_q;
endmodule

// File: rtl/rot_pick.sv
module rot_pick #(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 2,
   localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic [NUM_CORES-1:0]       elig_i,
   input  logic [IDX_W-1:0]           owner_i,
   output logic [NUM_PORTS-1:0]       sel_valid_o,
   output logic [NUM_PORTS*IDX_W-1:0] sel_idx_o
);
   import helper_arb_pkg::*;

   logic [NUM_CORES-1:0] rot;

   // Rotate so that bit 0 is the owner and bit i is owner+i (wrapped).
   always_comb begin
      rot = '0;
      for (int i = 0; i < NUM_CORES; i++)
         rot[i] = elig_i[ring_add(int'(owner_i), i, NUM_CORES)];
   end

   // Successive lowest-set-bit extraction, one stage per helper port.
   always_comb begin
      logic [NUM_CORES-1:0] avail;
      logic                 found;
      int unsigned          off;
      avail       = rot;
      sel_valid_o = '0;
      sel_idx_o   = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         found = 1'b0;
         off   = 0;
         for (int i = 0; i < NUM_CORES; i++) begin
            if (!found && avail[i]) begin
               found = 1'b1;
               off   = i;
            end
         end
         if (found) begin
            avail[off]                    = 1'b0;
            sel_valid_o[k]                = 1'b1;
            sel_idx_o[k*IDX_W +: IDX_W]   =
               IDX_W'(ring_add(int'(owner_i), off, NUM_CORES));
         end
      end
   end
endmodule

// File: rtl/port_steer.sv
module port_steer #(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 2,
   parameter int PAYLOAD_W = 32,
   localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic [NUM_PORTS-1:0]           sel_valid_i,
   input  logic [NUM_PORTS*IDX_W-1:0]     sel_idx_i,
   input  logic [NUM_CORES*PAYLOAD_W-1:0] payload_i,
   output logic [NUM_CORES-1:0]           grant_o,
   output logic [NUM_PORTS-1:0]           port_valid_o,
   output logic [NUM_PORTS*IDX_W-1:0]     port_core_o,
   output logic [NUM_PORTS*PAYLOAD_W-1:0] port_data_o
);
   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      logic [IDX_W-1:0] idx;
      assign idx = sel_idx_i[k*IDX_W +: IDX_W];
      assign port_valid_o[k] = sel_valid_i[k];
      assign port_core_o[k*IDX_W +: IDX_W] = sel_valid_i[k] ? idx : '0;
      assign port_data_o[k*PAYLOAD_W +: PAYLOAD_W] =
         sel_valid_i[k] ? payload_i[int'(idx)*PAYLOAD_W +: PAYLOAD_W] : '0;
   end

   always_comb begin
      grant_o = '0;
      for (int k = 0; k < NUM_PORTS; k++)
         if (sel_valid_i[k]) grant_o[sel_idx_i[k*IDX_W +: IDX_W]] = 1'b1;
   end
endmodule

// File: rtl/helper_turn_arb.sv
module helper_turn_arb #(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 2,
   parameter int PAYLOAD_W = 32,
   localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CORES-1:0]           req_i,
   input  logic [NUM_CORES-1:0]           flush_i,
   input  logic [NUM_CORES-1:0]           enable_i,
   input  logic [NUM_CORES*PAYLOAD_W-1:0] payload_i,
   output logic [IDX_W-1:0]               turn_o,
   output logic [NUM_CORES-1:0]           grant_o,
   output logic [NUM_PORTS-1:0]           port_valid_o,
   output logic [NUM_PORTS*IDX_W-1:0]     port_core_o,
   output logic [NUM_PORTS*PAYLOAD_W-1:0] port_data_o
);
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("helper_turn_arb: NUM_CORES must be at least 2");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > NUM_CORES) begin : g_bad_ports
      $error("helper_turn_arb: NUM_PORTS must lie in 1..NUM_CORES");
   end
   if (PAYLOAD_W < 1) begin : g_bad_width
      $error("helper_turn_arb: PAYLOAD_W must be positive");
   end

   logic [IDX_W-1:0]               turn;
   logic [NUM_CORES-1:0]           elig;
   logic [NUM_CORES*PAYLOAD_W-1:0] pay_q;
   logic [NUM_PORTS-1:0]           sel_valid;
   logic [NUM_PORTS*IDX_W-1:0]     sel_idx;

   turn_ring #(.NUM_CORES(NUM_CORES)) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .turn_o (turn)
   );

   req_stage #(.NUM_CORES(NUM_CORES), .PAYLOAD_W(PAYLOAD_W)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .flush_i   (flush_i),
      .enable_i  (enable_i),
      .payload_i (payload_i),
      .elig_o    (elig),
      .payload_o (pay_q)
   );

   rot_pick #(.NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS)) u_pick (
      .elig_i      (elig),
      .owner_i     (turn),
      .sel_valid_o (sel_valid),
      .sel_idx_o   (sel_idx)
   );

   port_steer #(.NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS),
                .PAYLOAD_W(PAYLOAD_W)) u_steer (
      .sel_valid_i  (sel_valid),
      .sel_idx_i    (sel_idx),
      .payload_i    (pay_q),
      .grant_o      (grant_o),
      .port_valid_o (port_valid_o),
      .port_core_o  (port_core_o),
      .port_data_o  (port_data_o)
   );

   assign turn_o = turn;
endmodule

// File: rtl/helper_turn_arb_chk.sv
module helper_turn_arb_chk #(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 2,
   parameter int PAYLOAD_W = 32,
   localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_CORES-1:0]           req_i,
   input logic [NUM_CORES-1:0]           flush_i,
   input logic [NUM_CORES-1:0]           enable_i,
   input logic [IDX_W-1:0]               turn_o,
   input logic [NUM_CORES-1:0]           grant_o,
   input logic [NUM_PORTS-1:0]           port_valid_o,
   input logic [NUM_PORTS*IDX_W-1:0]     port_core_o,
   input logic [NUM_PORTS*PAYLOAD_W-1:0] port_data_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CORES - 1);

   // R2: the turn advances by one each cycle and wraps
   a_r2_turn_steps: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |->
         turn_o == (($past(turn_o) == LAST) ? '0 : $past(turn_o) + IDX_W'(1)));

   // R8: one grant per valid port
   a_r8_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_o) == $countones(port_valid_o));

   // R3: an eligible owner is always on port 0
   a_r3_owner_first: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[turn_o] |-> (port_valid_o[0] && port_core_o[IDX_W-1:0] == turn_o));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      // R6, R7: a granted core was requesting, unflushed and enabled
      a_r7_masked_never_granted: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && grant_o[c]) |->
            $past(req_i[c] && !flush_i[c] && enable_i[c]));
   end

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      // R11: an idle port drives zeros
      a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !port_valid_o[k] |->
            (port_data_o[k*PAYLOAD_W +: PAYLOAD_W] == '0 &&
             port_core_o[k*IDX_W +: IDX_W] == '0));
      // R9: the core named on a valid port holds a grant
      a_r9_core_granted: assert property (@(posedge clk) disable iff (!rst_n)
         port_valid_o[k] |-> grant_o[port_core_o[k*IDX_W +: IDX_W]]);
      if (k > 0) begin : g_order
         // R5: valid ports fill from port 0 upward
         a_r5_ports_packed: assert property (@(posedge clk) disable iff (!rst_n)
            port_valid_o[k] |-> port_valid_o[k-1]);
      end
   end
endmodule

bind helper_turn_arb helper_turn_arb_chk #(
   .NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS), .PAYLOAD_W(PAYLOAD_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .flush_i      (flush_i),
   .enable_i     (enable_i),
   .turn_o       (turn_o),
   .grant_o      (grant_o),
   .port_valid_o (port_valid_o),
   .port_core_o  (port_core_o),
   .port_data_o  (port_data_o)
);

// File: tb/sim_helper_turn_arb.sv
`timescale 1ns/1ps
module sim_helper_turn_arb;
   localparam int N  = 4;
   localparam int P  = 2;
   localparam int W  = 32;
   localparam int IW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   req = '0, flush = '0, en = '0;
   logic [N*W-1:0] pay = '0;
   logic [IW-1:0]  turn;
   logic [N-1:0]   grant;
   logic [P-1:0]   pv;
   logic [P*IW-1:0] pc;
   logic [P*W-1:0] pd;

   int n_cmp = 0, n_bad = 0;
   int exp_turn = 0;
   bit done = 0;

   always #2 clk = ~clk;

   helper_turn_arb #(.NUM_CORES(N), .NUM_PORTS(P), .PAYLOAD_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .flush_i(flush), .enable_i(en),
      .payload_i(pay), .turn_o(turn), .grant_o(grant), .port_valid_o(pv),
      .port_core_o(pc), .port_data_o(pd));

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive one set of inputs, let one edge capture it, check the result.
   task automatic step(string tag, logic [N-1:0] r, logic [N-1:0] f,
                       logic [N-1:0] e);
      logic [N-1:0]   elig, eg, left;
      logic [N*W-1:0] p;
      int             c, cnt;
      for (int i = 0; i < N; i++) p[i*W +: W] = $urandom();
      req = r; flush = f; en = e; pay = p;
      @(posedge clk);
      @(negedge clk);
      exp_turn = (exp_turn + 1) % N;
      chk("R2 turn", 64'(turn), 64'(exp_turn));
      elig = r & ~f & e;   // R3, R6, R7 eligibility
      left = elig;
      eg   = '0;
      cnt  = 0;
      for (int k = 0; k < P; k++) begin
         c = -1;
         for (int i = 0; i < N; i++)
            if (c < 0 && left[(exp_turn + i) % N]) c = (exp_turn + i) % N;
         if (c >= 0) begin
            left[c] = 1'b0;
            eg[c]   = 1'b1;
            chk({tag, " R5 valid"}, 64'(pv[k]), 64'd1);
            chk({tag, " R4 core"}, 64'(pc[k*IW +: IW]), 64'(c));
            chk({tag, " R9 data"}, 64'(pd[k*W +: W]), 64'(p[c*W +: W]));
         end else begin
            chk({tag, " R5 valid"}, 64'(pv[k]), 64'd0);
            chk({tag, " R11 core"}, 64'(pc[k*IW +: IW]), 64'd0);
            chk({tag, " R11 data"}, 64'(pd[k*W +: W]), 64'd0);
         end
      end
      chk({tag, " R8 grant"}, 64'(grant), 64'(eg));
   endtask

   function automatic logic [N-1:0] bit_at(int i);
      return N'(1) << (i % N);
   endfunction

   initial begin
      int o;
      void'($urandom(32'h5EED_1234));
      req = '1; en = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 turn", 64'(turn), 64'd0);
      chk("R1 grant", 64'(grant), 64'd0);
      chk("R1 valid", 64'(pv), 64'd0);
      rst_n = 1'b1;
      exp_turn = 0;

      // R3: all eligible, owner first then its successor
      repeat (N) step("R3 all", '1, '0, '1);
      // R4: only the core just below the owner requests (wrap)
      for (int t = 0; t < N; t++) begin
         o = (exp_turn + 1) % N;
         step("R4 wrap", bit_at(o + N - 1), '0, '1);
      end
      // R6: owner flushed
      for (int t = 0; t < N; t++) begin
         o = (exp_turn + 1) % N;
         step("R6 flush", '1, bit_at(o), '1);
      end
      // R7: owner and owner+2 disabled
      for (int t = 0; t < N; t++) begin
         o = (exp_turn + 1) % N;
         step("R7 mask", '1, '0, ~(bit_at(o) | bit_at(o + 2)));
      end
      // R7: disabled core requesting alone gets nothing
      step("R7 alone", 4'b0100, '0, 4'b1011);
      // R11, R2: nobody asks, turn still moves
      repeat (3) step("R11 idle", '0, '0, '1);
      // R10: random mixes
      for (int t = 0; t < 400; t++)
         step("R10 rand", N'($urandom()), N'($urandom() & $urandom()),
              N'($urandom() | $urandom()));

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule